// File: doc/BRIEF.md
# Snoopable Victim Write-Back Buffer

This block sits beside a write-back cache and accepts dirty lines that the cache evicts on a miss. When a victim is parked here, the cache can fetch the missing block straight away. The parked line goes out to the bus later, after the fetch. The buffer is a small ordered queue. The oldest parked line is offered to the bus through a request/grant pair. The line leaves the buffer in the cycle the grant arrives.

A parked line is still the only up-to-date copy of its address, so every address seen on the bus is compared with the buffered entries. On a match the buffer reports a dirty result in the same cycle. It returns the line on the next cycle and drops the entry, so that line is never written back. A lookup port for the processor side reports whether a missing address is still parked here, so the line can be taken back instead of fetched again.

Top module: `wb_victim_buf`

## Requirements
- R1: After a synchronous active-low reset the buffer is empty: `push_ready` is 1, and `wb_req`, `snoop_dirty`, `snoop_data_valid` and `miss_hit` are 0.
- R2: A victim is taken at a rising edge when `push_valid` and `push_ready` are both 1. `push_ready` is 0 exactly when DEPTH entries are held. A push offered while `push_ready` is 0 is dropped, and that line is never offered to the bus.
- R3: While at least one entry is held, `wb_req` is 1 (except in the case of R8), and `wb_addr`/`wb_data` show the oldest held entry. Entries are offered in the order they were pushed.
- R4: A writeback transfer happens in any cycle with `wb_req` and `wb_gnt` both 1. The transferred entry is gone after that edge. A push in the same cycle is also taken.
- R5: In a cycle where `snoop_valid` is 1 and `snoop_addr` equals a held entry's address, `snoop_dirty` is 1 in that same cycle. Otherwise it is 0.
- R6: One cycle after a snoop hit, `snoop_data_valid` is 1 for one cycle and `snoop_data` holds the matched line.
- R7: An entry hit by a snoop is removed at that edge and is never written back. A grant on the oldest entry and a snoop hit on a different entry in the same cycle both remove their entries.
- R8: When a snoop hits the oldest entry, `wb_req` is 0 in that cycle, so a grant in that cycle transfers nothing.
- R9: In a cycle where `miss_valid` is 1 and `miss_addr` equals a held entry, `miss_hit` is 1 and `miss_data` is that entry's line. The lookup changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| push_valid | input | 1 | Cache offers an evicted dirty line |
| push_addr | input | ADDR_W | Line address of the offered victim |
| push_data | input | DATA_W | Line contents of the offered victim |
| push_ready | output | 1 | Buffer has room for a victim |
| wb_req | output | 1 | Bus request for the oldest entry |
| wb_gnt | input | 1 | Bus grant; transfer happens while `wb_req` is high |
| wb_addr | output | ADDR_W | Address of the oldest entry |
| wb_data | output | DATA_W | Line of the oldest entry |
| snoop_valid | input | 1 | A bus address is presented for checking |
| snoop_addr | input | ADDR_W | Snooped line address |
| snoop_dirty | output | 1 | Snooped address is held here (same cycle) |
| snoop_data_valid | output | 1 | `snoop_data` carries the hit line |
| snoop_data | output | DATA_W | Line returned one cycle after a hit |
| miss_valid | input | 1 | Processor-side lookup strobe |
| miss_addr | input | ADDR_W | Address of the processor miss |
| miss_hit | output | 1 | Missing line is parked here |
| miss_data | output | DATA_W | The parked line on a hit |

## Verification
The match logic assumes that no two held entries share an address. The cache never evicts the same line twice without first fetching it back. The one-hot check on the match vector relies on this. The stimulus keeps every pushed address distinct from those already held. It also never pushes an address in the same cycle that it snoops that address. Snoops that miss use addresses that were never pushed or that were already removed.

// File: rtl/vb_pkg.sv
// Package: default geometry shared by the victim buffer modules.
// Assumes: callers override these through the top-level parameters.
package vb_pkg;
    localparam int unsigned VB_ADDR_W = 32;
    localparam int unsigned VB_DATA_W = 64;
    localparam int unsigned VB_DEPTH  = 2;
endpackage

// File: rtl/vb_addr_match.sv
// Module: compares one probe address against every held entry and selects
// the matching line.
// Assumes: held addresses are unique, so at most one slot matches.
module vb_addr_match #(
    parameter int unsigned ADDR_W = vb_pkg::VB_ADDR_W,
    parameter int unsigned DATA_W = vb_pkg::VB_DATA_W,
    parameter int unsigned DEPTH  = vb_pkg::VB_DEPTH
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          probe_valid,
    input  logic [ADDR_W-1:0]             probe_addr,
    input  logic [DEPTH-1:0]              ent_valid,
    input  logic [DEPTH-1:0][ADDR_W-1:0]  ent_addr,
    input  logic [DEPTH-1:0][DATA_W-1:0]  ent_data,
    output logic [DEPTH-1:0]              hit_vec,
    output logic                          hit,
    output logic [DATA_W-1:0]             hit_data
);
    // One comparator per slot.
    for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
        assign hit_vec[s] = probe_valid && ent_valid[s] && (ent_addr[s] == probe_addr);
    end

    assign hit = |hit_vec;

    // OR-mux of the matching slot's line.
    always_comb begin
        hit_data = '0;
        for (int s = 0; s < DEPTH; s++) begin
            if (hit_vec[s]) hit_data = hit_data | ent_data[s];
        end
    end

    AST_MATCH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R5
endmodule

// File: rtl/vb_entry_queue.sv
// Module: ordered entry storage. Slot 0 is always the oldest entry. Removed
// entries (drain of slot 0, snoop cancel of any slot) are squeezed out, and
// a push is appended behind the survivors.
// Assumes: push_en is only raised while the queue is not full.
module vb_entry_queue #(
    parameter int unsigned ADDR_W = vb_pkg::VB_ADDR_W,
    parameter int unsigned DATA_W = vb_pkg::VB_DATA_W,
    parameter int unsigned DEPTH  = vb_pkg::VB_DEPTH
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push_en,
    input  logic [ADDR_W-1:0]             push_addr,
    input  logic [DATA_W-1:0]             push_data,
    input  logic                          pop_head,
    input  logic [DEPTH-1:0]              cancel_vec,
    output logic [DEPTH-1:0]              ent_valid,
    output logic [DEPTH-1:0][ADDR_W-1:0]  ent_addr,
    output logic [DEPTH-1:0][DATA_W-1:0]  ent_data,
    output logic                          full
);
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [DEPTH-1:0]             keep;
    logic [DEPTH-1:0]             nxt_valid;
    logic [DEPTH-1:0][ADDR_W-1:0] nxt_addr;
    logic [DEPTH-1:0][DATA_W-1:0] nxt_data;
    logic [CNT_W-1:0]             dst;

    // Slots that survive this cycle.
    for (genvar s = 0; s < DEPTH; s++) begin : g_keep
        if (s == 0) begin : g_head
            assign keep[s] = ent_valid[s] && !cancel_vec[s] && !pop_head;
        end else begin : g_tail
            assign keep[s] = ent_valid[s] && !cancel_vec[s];
        end
    end

    assign full = ent_valid[DEPTH-1];

    // Compact survivors toward slot 0, then append any push.
    always_comb begin
        nxt_valid = '0;
        nxt_addr  = ent_addr;
        nxt_data  = ent_data;
        dst       = '0;
        for (int s = 0; s < DEPTH; s++) begin
            if (keep[s]) begin
                nxt_valid[dst[IDX_W-1:0]] = 1'b1;
                nxt_addr[dst[IDX_W-1:0]]  = ent_addr[IDX_W'(s)];
                nxt_data[dst[IDX_W-1:0]]  = ent_data[IDX_W'(s)];
                dst = dst + 1'b1;
            end
        end
        if (push_en && (dst < CNT_W'(DEPTH))) begin
            nxt_valid[dst[IDX_W-1:0]] = 1'b1;
            nxt_addr[dst[IDX_W-1:0]]  = push_addr;
            nxt_data[dst[IDX_W-1:0]]  = push_data;
        end
    end

    // Register the queue state; reset clears only the valid bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
        end else begin
            ent_valid <= nxt_valid;
            ent_addr  <= nxt_addr;
            ent_data  <= nxt_data;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |-> !full); // R2

    AST_FIFO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_head && ent_valid[1] && !cancel_vec[1]) |=> (ent_addr[0] == $past(ent_addr[1]))); // R3
endmodule

// File: rtl/vb_drain_ctrl.sv
// Module: offers the oldest entry to the bus. It withholds the request when
// a snoop is taking that entry in the same cycle.
// Assumes: the grant is sampled only in cycles where the request is high.
module vb_drain_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic head_valid,
    input  logic head_cancel,
    input  logic wb_gnt,
    output logic wb_req,
    output logic drain_pop
);
    // Request gating and transfer detection.
    assign wb_req    = head_valid && !head_cancel;
    assign drain_pop = wb_req && wb_gnt;

    AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_gnt) |=> head_valid); // R3
endmodule

// File: rtl/vb_snoop_resp.sv
// Module: registers the snoop outcome so the matched line is driven on the
// cycle after the hit.
// Assumes: hit_data is meaningful only while hit is high.
module vb_snoop_resp #(
    parameter int unsigned DATA_W = vb_pkg::VB_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [DATA_W-1:0] hit_data,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_data
);
    // Capture the line on a hit; the valid flag lasts one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_data  <= '0;
        end else begin
            resp_valid <= hit;
            if (hit) resp_data <= hit_data;
        end
    end
endmodule

// File: rtl/wb_victim_buf.sv
// Module: victim write-back buffer with snoop checking. Victims are queued,
// drained oldest-first over a request/grant pair, and a snoop hit returns
// the line and cancels its writeback.
// Assumes: held addresses are unique; a snoop never names the address being
// pushed in the same cycle.
module wb_victim_buf #(
    parameter int unsigned ADDR_W = vb_pkg::VB_ADDR_W,
    parameter int unsigned DATA_W = vb_pkg::VB_DATA_W,
    parameter int unsigned DEPTH  = vb_pkg::VB_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    output logic              push_ready,
    output logic              wb_req,
    input  logic              wb_gnt,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              snoop_dirty,
    output logic              snoop_data_valid,
    output logic [DATA_W-1:0] snoop_data,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              miss_hit,
    output logic [DATA_W-1:0] miss_data
);
    logic [DEPTH-1:0]             q_valid;
    logic [DEPTH-1:0][ADDR_W-1:0] q_addr;
    logic [DEPTH-1:0][DATA_W-1:0] q_data;
    logic                         q_full;
    logic                         push_en;
    logic                         drain_pop;
    logic [DEPTH-1:0]             snp_vec;
    logic [DATA_W-1:0]            snp_line;
    logic [DEPTH-1:0]             miss_vec;

    // Accept a victim only when a slot is free.
    assign push_ready = !q_full;
    assign push_en    = push_valid && push_ready;
    assign wb_addr    = q_addr[0];
    assign wb_data    = q_data[0];

    vb_entry_queue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push_en(push_en), .push_addr(push_addr), .push_data(push_data),
        .pop_head(drain_pop), .cancel_vec(snp_vec),
        .ent_valid(q_valid), .ent_addr(q_addr), .ent_data(q_data), .full(q_full)
    );

    vb_addr_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_snoop_cmp (
        .clk(clk), .rst_n(rst_n),
        .probe_valid(snoop_valid), .probe_addr(snoop_addr),
        .ent_valid(q_valid), .ent_addr(q_addr), .ent_data(q_data),
        .hit_vec(snp_vec), .hit(snoop_dirty), .hit_data(snp_line)
    );

    vb_addr_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_miss_cmp (
        .clk(clk), .rst_n(rst_n),
        .probe_valid(miss_valid), .probe_addr(miss_addr),
        .ent_valid(q_valid), .ent_addr(q_addr), .ent_data(q_data),
        .hit_vec(miss_vec), .hit(miss_hit), .hit_data(miss_data)
    );

    vb_drain_ctrl u_drain (
        .clk(clk), .rst_n(rst_n),
        .head_valid(q_valid[0]), .head_cancel(snp_vec[0]), .wb_gnt(wb_gnt),
        .wb_req(wb_req), .drain_pop(drain_pop)
    );

    vb_snoop_resp #(.DATA_W(DATA_W)) u_resp (
        .clk(clk), .rst_n(rst_n),
        .hit(snoop_dirty), .hit_data(snp_line),
        .resp_valid(snoop_data_valid), .resp_data(snoop_data)
    );

    AST_SNOOP_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_dirty |=> snoop_data_valid); // R6

    AST_CANCEL_BLOCKS_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_valid && q_valid[0] && (snoop_addr == wb_addr)) |-> !wb_req); // R8

    AST_REQ_WHEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid != '0 && !snoop_dirty) |-> wb_req); // R3
endmodule

// File: tb/tb_wb_victim_buf.sv
module tb_wb_victim_buf;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_valid = 1'b0, wb_gnt = 1'b0, snoop_valid = 1'b0, miss_valid = 1'b0;
    logic [AW-1:0] push_addr = '0, snoop_addr = '0, miss_addr = '0;
    logic [DW-1:0] push_data = '0;
    logic          push_ready, wb_req, snoop_dirty, snoop_data_valid, miss_hit;
    logic [AW-1:0] wb_addr;
    logic [DW-1:0] wb_data, snoop_data, miss_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wb_victim_buf dut (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_addr(push_addr), .push_data(push_data), .push_ready(push_ready),
        .wb_req(wb_req), .wb_gnt(wb_gnt), .wb_addr(wb_addr), .wb_data(wb_data),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .snoop_dirty(snoop_dirty),
        .snoop_data_valid(snoop_data_valid), .snoop_data(snoop_data),
        .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_hit(miss_hit), .miss_data(miss_data)
    );

    // Line contents are a fixed function of the address.
    function automatic logic [DW-1:0] line_of(input logic [7:0] a);
        return {(32'(a) ^ 32'h5A5A_5A5A), 32'(a)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
        end
    endtask

    typedef struct packed {
        logic       pv; logic [7:0] pa;
        logic       sv; logic [7:0] sa;
        logic       g;  logic [7:0] ma;
        logic       e_rdy; logic e_req; logic [7:0] e_wa;
        logic       e_dirty; logic e_mhit; logic e_sdv; logic [7:0] e_sa;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b0,8'h00, 1'b0,8'h00, 1'b0,8'h00, 1'b1,1'b0,8'h00, 1'b0,1'b0,1'b0,8'h00},
        '{1'b1,8'h10, 1'b0,8'h00, 1'b0,8'h00, 1'b1,1'b0,8'h00, 1'b0,1'b0,1'b0,8'h00},
        '{1'b1,8'h20, 1'b0,8'h00, 1'b0,8'h10, 1'b1,1'b1,8'h10, 1'b0,1'b1,1'b0,8'h00},
        '{1'b1,8'h30, 1'b0,8'h00, 1'b0,8'h30, 1'b0,1'b1,8'h10, 1'b0,1'b0,1'b0,8'h00},
        '{1'b0,8'h00, 1'b1,8'h20, 1'b0,8'h00, 1'b0,1'b1,8'h10, 1'b1,1'b0,1'b0,8'h00},
        '{1'b0,8'h00, 1'b0,8'h00, 1'b1,8'h00, 1'b1,1'b1,8'h10, 1'b0,1'b0,1'b1,8'h20},
        '{1'b0,8'h00, 1'b0,8'h00, 1'b0,8'h20, 1'b1,1'b0,8'h00, 1'b0,1'b0,1'b0,8'h00},
        '{1'b1,8'h30, 1'b0,8'h00, 1'b0,8'h00, 1'b1,1'b0,8'h00, 1'b0,1'b0,1'b0,8'h00},
        '{1'b1,8'h40, 1'b0,8'h00, 1'b1,8'h00, 1'b1,1'b1,8'h30, 1'b0,1'b0,1'b0,8'h00},
        '{1'b0,8'h00, 1'b1,8'h40, 1'b1,8'h00, 1'b1,1'b0,8'h00, 1'b1,1'b0,1'b0,8'h00},
        '{1'b1,8'h10, 1'b1,8'h50, 1'b0,8'h00, 1'b1,1'b0,8'h00, 1'b0,1'b0,1'b1,8'h40},
        '{1'b0,8'h00, 1'b1,8'h60, 1'b0,8'h00, 1'b1,1'b1,8'h10, 1'b0,1'b0,1'b0,8'h00},
        '{1'b0,8'h00, 1'b0,8'h00, 1'b1,8'h10, 1'b1,1'b1,8'h10, 1'b0,1'b1,1'b0,8'h00},
        '{1'b0,8'h00, 1'b0,8'h00, 1'b0,8'h00, 1'b1,1'b0,8'h00, 1'b0,1'b0,1'b0,8'h00}
    };

    task automatic drive(input vec_t v);
        push_valid  = v.pv; push_addr = 32'(v.pa); push_data = line_of(v.pa);
        snoop_valid = v.sv; snoop_addr = 32'(v.sa);
        wb_gnt      = v.g;
        miss_valid  = (v.ma != 8'h00); miss_addr = 32'(v.ma);
    endtask

    task automatic idle();
        push_valid = 0; snoop_valid = 0; wb_gnt = 0; miss_valid = 0;
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %h expected %h", 64'd0, 64'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: state right after reset
        #1;
        chk(push_ready == 1'b1, "R1 ready", 64'(push_ready), 64'd1);
        chk(wb_req == 1'b0, "R1 req", 64'(wb_req), 64'd0);
        chk(snoop_data_valid == 1'b0, "R1 sdv", 64'(snoop_data_valid), 64'd0);

        // Vector walk: R2 R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i]);
            #1;
            chk(push_ready == VEC[i].e_rdy, "R2 push_ready", 64'(push_ready), 64'(VEC[i].e_rdy));
            chk(wb_req == VEC[i].e_req, "R3/R8 wb_req", 64'(wb_req), 64'(VEC[i].e_req));
            if (VEC[i].e_req) begin
                chk(wb_addr == 32'(VEC[i].e_wa), "R3 wb_addr", 64'(wb_addr), 64'(VEC[i].e_wa));
                chk(wb_data == line_of(VEC[i].e_wa), "R4 wb_data", wb_data, line_of(VEC[i].e_wa));
            end
            chk(snoop_dirty == VEC[i].e_dirty, "R5 snoop_dirty", 64'(snoop_dirty), 64'(VEC[i].e_dirty));
            chk(snoop_data_valid == VEC[i].e_sdv, "R6 snoop_data_valid", 64'(snoop_data_valid), 64'(VEC[i].e_sdv));
            if (VEC[i].e_sdv)
                chk(snoop_data == line_of(VEC[i].e_sa), "R6 snoop_data", snoop_data, line_of(VEC[i].e_sa));
            chk(miss_hit == VEC[i].e_mhit, "R9 miss_hit", 64'(miss_hit), 64'(VEC[i].e_mhit));
            if (VEC[i].e_mhit)
                chk(miss_data == line_of(VEC[i].ma), "R9 miss_data", miss_data, line_of(VEC[i].ma));
        end

        // R7: grant on the oldest entry and snoop on the second in one cycle
        @(negedge clk); idle(); push_valid = 1; push_addr = 32'h70; push_data = line_of(8'h70);
        @(negedge clk); push_addr = 32'h80; push_data = line_of(8'h80);
        @(negedge clk); idle(); snoop_valid = 1; snoop_addr = 32'h80; wb_gnt = 1;
        #1;
        chk(wb_req == 1'b1 && wb_addr == 32'h70, "R7 head offered", 64'(wb_addr), 64'h70);
        chk(snoop_dirty == 1'b1, "R7 second hit", 64'(snoop_dirty), 64'd1);
        @(negedge clk); idle();
        #1;
        chk(wb_req == 1'b0, "R7 both removed", 64'(wb_req), 64'd0);
        chk(snoop_data == line_of(8'h80) && snoop_data_valid, "R7 line returned", snoop_data, line_of(8'h80));

        // R1: reset while holding entries
        @(negedge clk); push_valid = 1; push_addr = 32'h90; push_data = line_of(8'h90);
        @(negedge clk); push_addr = 32'hA0; push_data = line_of(8'hA0);
        @(negedge clk); idle(); snoop_valid = 1; snoop_addr = 32'h90; rst_n = 1'b0;
        @(negedge clk); idle(); rst_n = 1'b1;
        #1;
        chk(wb_req == 1'b0, "R1 req after reset", 64'(wb_req), 64'd0);
        chk(push_ready == 1'b1, "R1 ready after reset", 64'(push_ready), 64'd1);
        chk(snoop_data_valid == 1'b0, "R1 sdv after reset", 64'(snoop_data_valid), 64'd0);
        miss_valid = 1; miss_addr = 32'hA0;
        #1;
        chk(miss_hit == 1'b0, "R1 miss after reset", 64'(miss_hit), 64'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule